// File: doc/BRIEF.md
# General-Purpose Pin Port with Bit-Atomic Latch Update

A 32-pin I/O port for a processor subsystem. A small register bus with separate write and read channels holds, for every pin, a function select, a direction bit, a pull-up disable bit and an output latch bit. Software can load the output latch as a whole word. It can also change single bits without a read-modify-write, through three write-only aliases that set, clear or invert the bits written as 1.

Each pin is driven either by its latch bit and direction bit or, when the function select picks the peripheral, by a peripheral's output and enable. Pin input levels pass through a synchronizer. A read of the data word returns the synchronized input levels, not the latch.

Top module: `gpio_port`

## Requirements
- R1: After reset, every pin is an input (`pin_oe_o` = 0), every pin uses the GPIO function, the output latch is 0 (`pin_o` = 0), every pull-up is on (`pin_pu_o` all ones), and the direction and function-select registers read as 0.
- R2: A write to address 0 (data) loads the output latch with `wr_data_i`. The new value appears on `pin_o` for GPIO-function pins on the cycle after the write edge. Without a latch write, the latch holds its value.
- R3: A write to address 1 (set) forces to 1 every latch bit whose `wr_data_i` bit is 1 and leaves the others unchanged.
- R4: A write to address 2 (clear) forces to 0 every latch bit whose `wr_data_i` bit is 1 and leaves the others unchanged.
- R5: A write to address 3 (toggle) inverts every latch bit whose `wr_data_i` bit is 1 and leaves the others unchanged.
- R6: Reads of addresses 1, 2 and 3 return 0.
- R7: A read of address 0 returns the pin levels delayed by SYNC_STAGES (default 2) clock edges, whatever the latch holds.
- R8: A write to address 4 loads the direction register. For a GPIO-function pin, `pin_oe_o` equals its direction bit (1 = output, 0 = input).
- R9: Address 6 holds the function select of pins 0..15 and address 7 that of pins 16..31, each in `wr_data_i[15:0]`. Bits 31:16 of the write are ignored and read back as 0. A select bit of 1 routes `alt_out_i` and `alt_oe_i` of that pin to `pin_o` and `pin_oe_o`. A select bit of 0 uses the latch and direction bits.
- R10: A write to address 5 loads the pull-up disable register. `pin_pu_o` is 1 (pull-up on) where a bit is 0, and 0 where a bit is 1.
- R11: A read pulse on `rd_en_i` gives `rd_valid_o` and `rd_data_o` on the next cycle. `rd_valid_o` is 0 in every other cycle. A read and a write of the same register in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |
| pin_pu_o | output | 32 | Pull-up enables |
| alt_out_i | input | 32 | Peripheral output values |
| alt_oe_i | input | 32 | Peripheral output enables |

## Verification
A write and a read can fall in the same cycle because the two channels are independent. The bench issues both in one cycle: to the direction register, where the read must return the old contents and a later read the new, and to the data address, where the read must return synchronized pin levels and never the value just written to the latch. A scoreboard queue holds the expected read values, and the bench checks the pin outputs on the cycle after the write edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA    = 3'd0,
    SEL_SET     = 3'd1,
    SEL_CLR     = 3'd2,
    SEL_TGL     = 3'd3,
    SEL_DIR     = 3'd4,
    SEL_PUDIS   = 3'd5,
    SEL_FUNC_LO = 3'd6,
    SEL_FUNC_HI = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NPINS-1:0]  pin_sync_i,
  output logic [NPINS-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic [NPINS-1:0]  lat_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  pud_o,
  output logic [NPINS-1:0]  fsel_o
);
  localparam int HALF = NPINS / 2;
  localparam int UPW  = NPINS - HALF;

  logic [NPINS-1:0] lat_q, dir_q, pud_q, fsel_q, rdata_q, rd_mux;
  logic             rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      dir_q  <= '0;
      pud_q  <= '0;
      fsel_q <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_addr_i))
        SEL_DATA:    lat_q <= wr_data_i;
        SEL_SET:     lat_q <= lat_q | wr_data_i;
        SEL_CLR:     lat_q <= lat_q & ~wr_data_i;
        SEL_TGL:     lat_q <= lat_q ^ wr_data_i;
        SEL_DIR:     dir_q <= wr_data_i;
        SEL_PUDIS:   pud_q <= wr_data_i;
        SEL_FUNC_LO: fsel_q[HALF-1:0] <= wr_data_i[HALF-1:0];
        SEL_FUNC_HI: fsel_q[NPINS-1:HALF] <= wr_data_i[UPW-1:0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr_i))
      SEL_DATA:    rd_mux = pin_sync_i;
      SEL_DIR:     rd_mux = dir_q;
      SEL_PUDIS:   rd_mux = pud_q;
      SEL_FUNC_LO: rd_mux = {{UPW{1'b0}}, fsel_q[HALF-1:0]};
      SEL_FUNC_HI: rd_mux = {{HALF{1'b0}}, fsel_q[NPINS-1:HALF]};
      default:     rd_mux = '0; // write-only aliases
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rd_data_o  = rdata_q;
  assign rd_valid_o = rvalid_q;
  assign lat_o      = lat_q;
  assign dir_o      = dir_q;
  assign pud_o      = pud_q;
  assign fsel_o     = fsel_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] lat_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] pud_i,
  input  logic [NPINS-1:0] fsel_i,
  input  logic [NPINS-1:0] alt_out_i,
  input  logic [NPINS-1:0] alt_oe_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pin_pu_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_o[i]    = fsel_i[i] ? alt_out_i[i] : lat_i[i];
    assign pin_oe_o[i] = fsel_i[i] ? alt_oe_i[i]  : dir_i[i];
    assign pin_pu_o[i] = ~pud_i[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NPINS-1:0]  rd_data_o,
  output logic              rd_valid_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic [NPINS-1:0]  pin_pu_o,
  input  logic [NPINS-1:0]  alt_out_i,
  input  logic [NPINS-1:0]  alt_oe_i
);
  logic [NPINS-1:0] pin_sync, lat_q, dir_q, pud_q, fsel_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i, .rd_addr_i,
    .pin_sync_i(pin_sync),
    .rd_data_o, .rd_valid_o,
    .lat_o(lat_q), .dir_o(dir_q), .pud_o(pud_q), .fsel_o(fsel_q)
  );

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .lat_i(lat_q), .dir_i(dir_q), .pud_i(pud_q), .fsel_i(fsel_q),
    .alt_out_i, .alt_oe_i,
    .pin_o, .pin_oe_o, .pin_pu_o
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [NPINS-1:0]  wr_data_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [NPINS-1:0]  rd_data_o,
  input logic              rd_valid_o,
  input logic [NPINS-1:0]  lat_i
);
  logic lat_wr, alias_rd;
  assign lat_wr   = wr_en_i && (wr_addr_i <= 3'(SEL_TGL));
  assign alias_rd = rd_en_i && (rd_addr_i == 3'(SEL_SET) || rd_addr_i == 3'(SEL_CLR) ||
                                rd_addr_i == 3'(SEL_TGL));

  assert_data_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'(SEL_DATA)) |=> lat_i == $past(wr_data_i));

  assert_latch_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_wr |=> $stable(lat_i));

  assert_set_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'(SEL_SET)) |=>
      ((lat_i & $past(wr_data_i)) == $past(wr_data_i)) &&
      ((lat_i & ~$past(wr_data_i)) == ($past(lat_i) & ~$past(wr_data_i))));

  assert_clr_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'(SEL_CLR)) |=>
      ((lat_i & $past(wr_data_i)) == '0) &&
      ((lat_i & ~$past(wr_data_i)) == ($past(lat_i) & ~$past(wr_data_i))));

  assert_tgl_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'(SEL_TGL)) |=> lat_i == ($past(lat_i) ^ $past(wr_data_i)));

  assert_alias_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_rd |=> rd_data_o == '0);

  assert_rd_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
  .rd_en_i, .rd_addr_i, .rd_data_o, .rd_valid_o, .lat_i(lat_q)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   wr_addr = '0, rd_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data, pin_out, pin_oe, pin_pu;
  logic         rd_valid;
  logic [N-1:0] pin_in = '0, alt_out = '0, alt_oe = '0;

  int n_tests = 0, n_fail = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic [N-1:0] m_lat = '0, m_dir = '0, m_fsel = '0;

  always #2.5 clk = ~clk;

  gpio_port u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .pin_pu_o(pin_pu),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe)
  );

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rd_valid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rd_valid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [N-1:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_rd(logic [2:0] a, logic [N-1:0] d, logic [N-1:0] exp, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  function automatic logic [N-1:0] exp_out();
    return (m_lat & ~m_fsel) | (alt_out & m_fsel);
  endfunction
  function automatic logic [N-1:0] exp_oe();
    return (m_dir & ~m_fsel) | (alt_oe & m_fsel);
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe_o", pin_oe, '0);
    chk("R1 pin_o", pin_out, '0);
    chk("R1 pin_pu_o", pin_pu, '1);
    chk("R11 rd_valid_o in reset", {31'd0, rd_valid}, '0);
    rst_ni = 1'b1;
    rd(3'd4, '0, "R1 dir reads 0");
    rd(3'd6, '0, "R1 func lo reads 0");
    rd(3'd7, '0, "R1 func hi reads 0");

    // R8 direction
    wr(3'd4, '1); m_dir = '1;
    chk("R8 pin_oe_o all out", pin_oe, exp_oe());

    // R2 direct load and hold
    wr(3'd0, 32'hA5A5_0F0F); m_lat = 32'hA5A5_0F0F;
    chk("R2 data load", pin_out, exp_out());
    repeat (3) @(negedge clk);
    chk("R2 latch holds", pin_out, exp_out());

    // R3 / R4 / R5 aliases
    wr(3'd1, 32'h0000_00F0); m_lat = m_lat | 32'h0000_00F0;
    chk("R3 set", pin_out, exp_out());
    wr(3'd2, 32'h0F00_000F); m_lat = m_lat & ~32'h0F00_000F;
    chk("R4 clear", pin_out, exp_out());
    wr(3'd3, 32'hFFFF_0000); m_lat = m_lat ^ 32'hFFFF_0000;
    chk("R5 toggle", pin_out, exp_out());
    wr(3'd1, '0);
    chk("R3 set of zeros no change", pin_out, exp_out());
    wr(3'd3, 32'h8000_0001); m_lat = m_lat ^ 32'h8000_0001;
    chk("R5 toggle edge bits", pin_out, exp_out());

    // R6 aliases read zero
    rd(3'd1, '0, "R6 set reads 0");
    rd(3'd2, '0, "R6 clear reads 0");
    rd(3'd3, '0, "R6 toggle reads 0");

    // R7 synchronized input, two-edge latency
    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(3'd0, 32'h1234_5678, "R7 data read pins");
    @(negedge clk);
    pin_in = 32'hCAFE_F00D;
    rd_en = 1'b1; rd_addr = 3'd0;
    exp_q.push_back(32'h1234_5678); tag_q.push_back("R7 latency stage 0");
    @(negedge clk);
    exp_q.push_back(32'h1234_5678); tag_q.push_back("R7 latency stage 1");
    @(negedge clk);
    exp_q.push_back(32'hCAFE_F00D); tag_q.push_back("R7 latency stage 2");
    @(negedge clk);
    rd_en = 1'b0;

    // R10 pull-up disable
    wr(3'd5, 32'h0000_FFFF);
    chk("R10 pull-up", pin_pu, 32'hFFFF_0000);

    // R9 function select
    wr(3'd6, 32'hFFFF_00FF); m_fsel[15:0] = 16'h00FF;
    wr(3'd7, 32'hFFFF_8001); m_fsel[31:16] = 16'h8001;
    rd(3'd6, 32'h0000_00FF, "R9 func lo upper ignored");
    rd(3'd7, 32'h0000_8001, "R9 func hi upper ignored");
    alt_out = '0; alt_oe = '0;
    @(negedge clk);
    chk("R9 alt low out", pin_out, exp_out());
    chk("R9 alt low oe", pin_oe, exp_oe());
    alt_out = '1; alt_oe = '1;
    @(negedge clk);
    chk("R9 alt high out", pin_out, exp_out());
    chk("R9 alt high oe", pin_oe, exp_oe());
    wr(3'd0, '0); m_lat = '0;
    chk("R9 alt pins ignore latch", pin_out, exp_out());

    // R11 same-cycle read and write
    wr_rd(3'd4, 32'h0000_00AA, m_dir, "R11 read before write");
    m_dir = 32'h0000_00AA;
    rd(3'd4, m_dir, "R11 read after write");
    chk("R8 oe after dir change", pin_oe, exp_oe());
    wr_rd(3'd0, 32'h5555_5555, pin_in, "R7 same-cycle data read sees pins");
    m_lat = 32'h5555_5555;
    chk("R2 latch load beside read", pin_out, exp_out());

    repeat (3) @(negedge clk);
    chk("R11 all reads answered", exp_q.size(), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule